// File: doc/BRIEF.md
# TDM Timeslot Byte Receiver

This block is the receive end of a time-division multiplexed serial link. The link carries repeating frames of 256 bits, made of 32 timeslots of 8 bits each. A local frame position counter is pulled into step with the far-end transmitter by a sync input. Each serial bit is shifted into a serial-to-parallel register, one bit per clock, most significant bit first.

When the counter reaches the last bit of a timeslot, the block copies the assembled byte into a holding register. It tags the byte with its timeslot number and raises a one-clock valid strobe. The holding register keeps its value while the following byte is shifting in, so downstream logic has a whole timeslot to pick it up.

Clock recovery, line decoding and frame-alignment search happen upstream. This block only needs a sync pulse placed one bit before the first bit of a frame.

Top module: `tdm_slot_deser`

## Requirements
- R1: After reset is released, the bit sampled at the first rising clock edge is taken as timeslot 0, bit 0, and the following bits count up from there.
- R2: When `sync_in` is high at a rising edge, the bit sampled at the next edge is timeslot 0, bit 0, whatever the count was. A byte whose last bit is sampled at that same edge is still reported normally.
- R3: The frame position wraps from bit 255 (timeslot 31, bit 7) back to bit 0 (timeslot 0, bit 0) without a sync pulse.
- R4: One bit is sampled per rising edge, MSB first: the first bit of a timeslot lands in `hold_data[7]` and the last bit lands in `hold_data[0]`.
- R5: `hold_valid` is high for exactly one clock, in the cycle after the edge that samples the last bit of a timeslot. `hold_data` and `hold_slot` take their new values on that same edge.
- R6: `hold_slot` carries the timeslot number (0 to 31) of the byte in `hold_data`.
- R7: Between strobes, `hold_data` and `hold_slot` keep their values while the next byte shifts in.
- R8: While `rst_n` is low, `hold_data`, `hold_slot` and `hold_valid` are all zero.
- R9: If a sync pulse arrives partway through a timeslot, the bits gathered so far are discarded. No strobe is given for them, and the next strobe comes 8 bits after the sync pulse, carrying timeslot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit is sampled per rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_in | input | 1 | Serial data from the line |
| sync_in | input | 1 | Frame alignment pulse, high one bit before timeslot 0, bit 0 |
| hold_data | output | 8 | Last completed timeslot byte |
| hold_slot | output | 5 | Timeslot number of `hold_data` |
| hold_valid | output | 1 | One-clock strobe marking a newly captured byte |

## Verification
The bench uses the default configuration of 8-bit timeslots and 32 slots per frame. A 256-bit frame lasts only 256 clocks, so every timeslot number, the wrap from bit 255 to bit 0, and re-alignment at several points in a slot can all be covered in a few thousand cycles. The bench acts as the transmitter, building frames from arithmetic byte patterns (mixed, all zeros, all ones, walking one). It predicts each strobe's byte and slot from its own frame position count, and checks every cycle in between for both the absence of a strobe and unchanged holding outputs.

// File: rtl/tdm_deser_pkg.sv
package tdm_deser_pkg;

  // Timeslot index of a frame bit position.
  function automatic int slot_of(input int pos, input int slot_bits);
    return pos / slot_bits;
  endfunction

  // Bit index inside its timeslot (0 = first bit on the line).
  function automatic int bit_of(input int pos, input int slot_bits);
    return pos % slot_bits;
  endfunction

  // True when the position holds the final bit of a timeslot.
  function automatic bit ends_slot(input int pos, input int slot_bits);
    return bit_of(pos, slot_bits) == slot_bits - 1;
  endfunction

  // Position that follows pos within a frame of frame_bits bits.
  function automatic int advance_pos(input int pos, input int frame_bits);
    return (pos >= frame_bits - 1) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/tdm_bit_counter.sv
module tdm_bit_counter
  import tdm_deser_pkg::*;
#(
  parameter int SLOT_BITS = 8,
  parameter int NUM_SLOTS = 32,
  localparam int FRAME_BITS = SLOT_BITS * NUM_SLOTS,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_in,
  output logic [CNT_W-1:0]  pos,
  output logic [SLOT_W-1:0] cur_slot,
  output logic              last_bit
);

  // pos = frame position of the bit sampled at the coming edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pos <= '0;
    else if (sync_in)
      pos <= '0;
    else
      pos <= CNT_W'(advance_pos(int'(pos), FRAME_BITS));
  end

  always_comb begin
    cur_slot = SLOT_W'(slot_of(int'(pos), SLOT_BITS));
    last_bit = ends_slot(int'(pos), SLOT_BITS);
  end

  // R2: sync always restarts the frame count
  p_sync_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> (pos == '0));

  // R3: final frame bit rolls over to zero
  p_frame_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pos) == FRAME_BITS - 1 && !sync_in) |=> (pos == '0));

  // R3: count never leaves the frame
  p_pos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pos) < FRAME_BITS);

endmodule

// File: rtl/tdm_sipo.sv
module tdm_sipo #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_in,
  output logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] next_word
);

  // Stage 0 takes the line; each later stage takes its lower neighbour,
  // so the earliest bit ends up in the MSB.
  for (genvar i = 0; i < WIDTH; i++) begin : g_stage
    logic d_in;
    if (i == 0) begin : g_head
      assign d_in = ser_in;
    end else begin : g_body
      assign d_in = word[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word[i] <= 1'b0;
      else        word[i] <= d_in;
    end
  end

  // Contents as they will stand after the coming edge.
  assign next_word = {word[WIDTH-2:0], ser_in};

  // R4: new line bit enters at the LSB, older bits move toward the MSB
  p_shift_msb_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (word[0] == $past(ser_in)) && (word[WIDTH-1:1] == $past(word[WIDTH-2:0])));

endmodule

// File: rtl/tdm_hold_stage.sv
module tdm_hold_stage #(
  parameter int WIDTH  = 8,
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [WIDTH-1:0]  cap_word,
  input  logic [SLOT_W-1:0] cap_slot,
  output logic [WIDTH-1:0]  hold_data,
  output logic [SLOT_W-1:0] hold_slot,
  output logic              hold_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data  <= '0;
      hold_slot  <= '0;
      hold_valid <= 1'b0;
    end else begin
      hold_valid <= capture;
      if (capture) begin
        hold_data <= cap_word;
        hold_slot <= cap_slot;
      end
    end
  end

  // R7: outputs only move together with a strobe
  p_hold_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_valid |-> ($stable(hold_data) && $stable(hold_slot)));

endmodule

// File: rtl/tdm_slot_deser.sv
module tdm_slot_deser #(
  parameter int SLOT_BITS = 8,
  parameter int NUM_SLOTS = 32,
  localparam int FRAME_BITS = SLOT_BITS * NUM_SLOTS,
  localparam int CNT_W = $clog2(FRAME_BITS),
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_in,
  input  logic                 sync_in,
  output logic [SLOT_BITS-1:0] hold_data,
  output logic [SLOT_W-1:0]    hold_slot,
  output logic                 hold_valid
);

  // Named internal events
  logic [CNT_W-1:0]     pos;
  logic [SLOT_W-1:0]    cur_slot;
  logic                 last_bit;
  logic [SLOT_BITS-1:0] sipo_word;
  logic [SLOT_BITS-1:0] sipo_next;

  tdm_bit_counter #(
    .SLOT_BITS (SLOT_BITS),
    .NUM_SLOTS (NUM_SLOTS)
  ) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .pos      (pos),
    .cur_slot (cur_slot),
    .last_bit (last_bit)
  );

  tdm_sipo #(
    .WIDTH (SLOT_BITS)
  ) u_sipo (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_in    (ser_in),
    .word      (sipo_word),
    .next_word (sipo_next)
  );

  tdm_hold_stage #(
    .WIDTH  (SLOT_BITS),
    .SLOT_W (SLOT_W)
  ) u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .capture    (last_bit),
    .cap_word   (sipo_next),
    .cap_slot   (cur_slot),
    .hold_data  (hold_data),
    .hold_slot  (hold_slot),
    .hold_valid (hold_valid)
  );

  // R5: strobe follows only the last bit of a timeslot
  p_strobe_on_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> $past(last_bit));

  // R5: strobe never lasts two cycles
  p_strobe_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |=> !hold_valid);

  // R4: captured byte equals the shift register with the final bit included
  p_hold_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> (hold_data == $past(sipo_next)) && (hold_data == sipo_word));

  // R6: tag matches the slot being completed
  p_hold_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_valid |-> (hold_slot == $past(cur_slot)));

  // R9: no strobe in the cycle after the first post-sync bit
  p_sync_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_in |=> ##1 !hold_valid);

  // R8: outputs cleared while reset is held
  always_comb begin
    if (!rst_n) begin
      a_reset_clear_r8: assert (hold_data == '0 && hold_slot == '0 && !hold_valid);
    end
  end

endmodule

// File: tb/tdm_slot_deser_bench.sv
module tdm_slot_deser_bench;

  localparam int CLK_PERIOD = 10;
  localparam int SB = 8;
  localparam int NS = 32;
  localparam int FB = SB * NS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ser_in;
  logic       sync_in;
  logic [7:0] hold_data;
  logic [4:0] hold_slot;
  logic       hold_valid;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [7:0] exp_sr;
  int         exp_pos;
  logic [7:0] last_data;
  int         last_slot;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_slot_deser u_tdm_slot_deser (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_in     (ser_in),
    .sync_in    (sync_in),
    .hold_data  (hold_data),
    .hold_slot  (hold_slot),
    .hold_valid (hold_valid)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] tx_byte(input int mode, input int f, input int s);
    case (mode)
      1:       return 8'h00;
      2:       return 8'hFF;
      3:       return 8'h80 >> (s % 8);
      default: return 8'((s * 37 + f * 91 + 5) % 256);
    endcase
  endfunction

  function automatic logic tx_bit(input int mode, input int f, input int p);
    logic [7:0] b;
    b = tx_byte(mode, f, p / SB);
    return b[7 - (p % SB)];
  endfunction

  // Drive one bit (called at a negedge), let one rising edge pass, check.
  task automatic cycle(input logic b, input logic s, input string tag);
    ser_in  = b;
    sync_in = s;
    @(negedge clk);
    exp_sr = {exp_sr[6:0], b};
    if (exp_pos % SB == SB - 1) begin
      chk(hold_valid == 1'b1, {tag, "/R5"}, "strobe", int'(hold_valid), 1);
      chk(hold_data == exp_sr, {tag, "/R4"}, "byte", int'(hold_data), int'(exp_sr));
      chk(int'(hold_slot) == exp_pos / SB, {tag, "/R6"}, "slot", int'(hold_slot), exp_pos / SB);
      last_data = exp_sr;
      last_slot = exp_pos / SB;
    end else begin
      chk(hold_valid == 1'b0, {tag, "/R5"}, "no strobe", int'(hold_valid), 0);
      chk(hold_data == last_data && int'(hold_slot) == last_slot, {tag, "/R7"},
          "held byte", int'(hold_data), int'(last_data));
    end
    exp_pos = s ? 0 : (exp_pos + 1) % FB;
  endtask

  task automatic send_frame(input int mode, input int f, input string tag);
    for (int p = 0; p < FB; p++) cycle(tx_bit(mode, f, p), 1'b0, tag);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    rst_n   = 1'b0;
    ser_in  = 1'b0;
    sync_in = 1'b0;
    exp_sr    = '0;
    exp_pos   = 0;
    last_data = '0;
    last_slot = 0;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(hold_data == 8'h00, "R8", "reset byte", int'(hold_data), 0);
    chk(hold_slot == 5'd0, "R8", "reset slot", int'(hold_slot), 0);
    chk(hold_valid == 1'b0, "R8", "reset strobe", int'(hold_valid), 0);
    rst_n = 1'b1;

    // R1: free-running count from reset, no sync
    send_frame(0, 0, "R1");
    // R3: next frame follows the wrap with no sync
    send_frame(0, 1, "R3");

    // R9: three bits then sync on the fourth: partial slot dropped
    cycle(1'b1, 1'b0, "R9");
    cycle(1'b0, 1'b0, "R9");
    cycle(1'b1, 1'b0, "R9");
    cycle(1'b1, 1'b1, "R9");
    send_frame(1, 2, "R2");
    send_frame(2, 3, "R4");

    // R2: sync on the last bit of slot 0; that byte is still delivered
    for (int p = 0; p < SB; p++) cycle(tx_bit(0, 9, p) ^ p[0], (p == SB - 1), "R2");
    send_frame(3, 4, "R4");

    // R2: sync in mid-frame (slot 17 bit 2), then a mixed frame
    for (int p = 0; p < 17 * SB + 2; p++) cycle(tx_bit(0, 5, p), 1'b0, "R2");
    cycle(1'b0, 1'b1, "R9");
    send_frame(0, 6, "R2");
    send_frame(0, 7, "R3");

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

endmodule